// File: doc/BRIEF.md
# Dual-Mode PWM Pulse Generator

This block is the counter and compare stage of a multi-channel pulse-width modulator. A prescaler divides the system clock by a power of two and produces a count tick. A 15-bit counter runs against a programmable top value, in one of two modes:

- **Edge-aligned:** the counter only counts up.
- **Center-aligned:** the counter counts up, then back down.

Each channel holds a 16-bit duty word. The upper bit chooses the output polarity, and the lower 15 bits give the compare value.

Duty words and the top value come in on a valid/ready load port. Ready is raised only when the block is idle, or in the cycle that closes a period. Because of this, new values never take effect in the middle of a period.

The back-pressure rule is simple:

- The producer presents `ld_valid_i` with its data and holds both steady until it sees `ld_ready_o` high at a clock edge.
- `ld_ready_o` never depends on `ld_valid_i`.

Start and stop are plain one-cycle pulses. A stop request is honoured at the end of the current period. A one-cycle strobe marks the start of every new period.

Top module: `pwm_pulse_gen`

## Requirements
- R1: After reset all PWM outputs are low, `period_end_o` is low and `ld_ready_o` is high.
- R2: While running, the counter advances once every 2^P clock cycles, where P is the 3-bit prescale code (0 to 7) sampled on start; the first advance comes 2^P cycles after the start edge.
- R3: In edge-aligned mode (mode 0) the counter steps 0, 1, ..., top-1 and then wraps to 0, so a period lasts top counter steps.
- R4: In center-aligned mode (mode 1) the counter steps 0, 1, ..., top-1, then holds top-1 for one more step and goes down to 0, so a period lasts 2*top counter steps.
- R5: Channel i uses duty word bits [16*i+15 : 16*i] of `ld_duty_i`. With bit 15 of that word at 0, the output is high while the counter is below bits 14..0; with bit 15 at 1 the output is inverted. A compare value of top or more keeps a polarity-0 output high for the whole period.
- R6: `period_end_o` pulses high for one cycle in the cycle after the last counter step of each period.
- R7: `ld_ready_o` is high exactly when the block is idle, or in the cycle holding the last step of a period. On valid and ready, the duty words and top are taken together. At no other time do the active values change.
- R8: A stop pulse stops the block at the end of the current period, after which all outputs stay low. A start pulse while running is ignored, and so is a stop pulse while idle.
- R9: A channel whose bit in `ch_en_i` is 0 is unconnected, and its output is held low.
- R10: A loaded top value of 0 is treated as 1.
- R11: The counting mode and prescale code are sampled only on start. Changes to them while running have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse, used only while idle |
| stop_i | input | 1 | One-cycle stop request, applied at period end |
| mode_i | input | 1 | Counting mode: 0 edge-aligned, 1 center-aligned |
| prescale_i | input | PSW (3) | Prescale code P, dividing by 2^P |
| ch_en_i | input | NCH (4) | Per-channel connect enable |
| ld_valid_i | input | 1 | Load port valid |
| ld_ready_o | output | 1 | Load port ready |
| ld_duty_i | input | NCH*16 | Duty words, channel i at bits [16*i+15:16*i] |
| ld_top_i | input | CW (15) | Counter top value |
| pwm_o | output | NCH (4) | PWM outputs |
| period_end_o | output | 1 | One-cycle period boundary strobe |

## Verification
The assertions rely on the following input behaviour:

- `ld_valid_i` and its data are held until taken.
- The mode and prescale inputs are consumed only at a start edge.
- A top of 0 is clamped, which keeps the counter strictly below top.

The stimulus raises `ld_valid_i` and drops it only after the cycle in which the reference model sees the handshake fire. It drives start and stop as single-cycle pulses. It deliberately wiggles the mode and prescale inputs mid-run, and pulses start while already running, so that the property checking behaviour around stop and the hold checks on the top value meet those cases.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  typedef enum logic {
    CNT_EDGE   = 1'b0,
    CNT_CENTER = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [PSW-1:0] code,
  output logic           tick
);
  localparam int DW = (1 << PSW) - 1;

  logic [DW-1:0] pcnt;
  logic [DW:0]   span;
  logic [DW-1:0] mask;

  assign span = ((DW+1)'(1) << code) - (DW+1)'(1);
  assign mask = DW'(span);
  assign tick = en && ((pcnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (en)  pcnt <= pcnt + DW'(1);
  end

  // R2: with any division above one, ticks never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0) |=> !tick)
    else $error("tick spacing broken");
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_gen_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  cnt_mode_e     mode,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          dir_up,
  output logic          last
);
  logic at_peak;

  assign at_peak = (cnt == top - CW'(1));
  assign last    = (mode == CNT_CENTER) ? (!dir_up && cnt == '0) : at_peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (clr) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      if (last) begin
        cnt    <= '0;
        dir_up <= 1'b1;
      end else if (mode == CNT_EDGE) begin
        cnt <= cnt + CW'(1);
      end else if (dir_up) begin
        if (at_peak) dir_up <= 1'b0;
        else         cnt    <= cnt + CW'(1);
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R3: the count never reaches the top value
  p_cnt_below_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < top)
    else $error("counter reached top");

  // R4: a center-aligned turn holds the peak value for one step
  p_center_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CNT_CENTER && tick && dir_up && at_peak && !clr) |=> (!dir_up && $stable(cnt)))
    else $error("center turn wrong");
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 15
) (
  input  logic          run,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW:0]   word,
  output logic          pwm
);
  logic below;

  assign below = cnt < word[CW-1:0];
  assign pwm   = run && en && (below ^ word[CW]);
endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen
  import pwm_gen_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 15,
  parameter int PSW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             mode_i,
  input  logic [PSW-1:0]   prescale_i,
  input  logic [NCH-1:0]   ch_en_i,
  input  logic             ld_valid_i,
  output logic             ld_ready_o,
  input  logic [NCH*(CW+1)-1:0] ld_duty_i,
  input  logic [CW-1:0]    ld_top_i,
  output logic [NCH-1:0]   pwm_o,
  output logic             period_end_o
);
  localparam int WW = CW + 1;

  logic            running, stop_pend;
  cnt_mode_e       mode_q;
  logic [PSW-1:0]  ps_q;
  logic [CW-1:0]   top_q, top_in, cnt;
  logic [NCH*WW-1:0] duty_q;
  logic            tick, last, dir_up, wrap, load_fire, begin_run;

  assign begin_run  = start_i && !running;
  assign wrap       = running && tick && last;
  assign ld_ready_o = !running || wrap;
  assign load_fire  = ld_valid_i && ld_ready_o;
  assign top_in     = (ld_top_i == '0) ? CW'(1) : ld_top_i;

  pwm_prescaler #(.PSW(PSW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(begin_run), .en(running),
    .code(ps_q), .tick(tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(begin_run), .tick(tick),
    .mode(mode_q), .top(top_q), .cnt(cnt), .dir_up(dir_up), .last(last)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .run(running), .en(ch_en_i[i]), .cnt(cnt),
      .word(duty_q[i*WW +: WW]), .pwm(pwm_o[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running      <= 1'b0;
      stop_pend    <= 1'b0;
      mode_q       <= CNT_EDGE;
      ps_q         <= '0;
      top_q        <= CW'(1);
      duty_q       <= '0;
      period_end_o <= 1'b0;
    end else begin
      period_end_o <= wrap;
      if (load_fire) begin
        top_q  <= top_in;
        duty_q <= ld_duty_i;
      end
      if (!running) begin
        if (start_i) begin
          running   <= 1'b1;
          stop_pend <= 1'b0;
          mode_q    <= cnt_mode_e'(mode_i);
          ps_q      <= prescale_i;
        end
      end else if (wrap) begin
        stop_pend <= 1'b0;
        if (stop_pend || stop_i) running <= 1'b0;
      end else if (stop_i) begin
        stop_pend <= 1'b1;
      end
    end
  end

  // R6: a period strobe while running coincides with a fresh rising count at zero
  p_pend_new_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end_o && running) |-> (cnt == '0 && dir_up))
    else $error("period strobe misplaced");

  // R8: the block only stops on a period boundary
  p_stop_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(wrap))
    else $error("stopped mid-period");

  // R8: idle outputs are low
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_o == '0))
    else $error("output active while idle");

  // R7: active top changes only through an accepted load
  p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(top_q))
    else $error("top changed without load");

  // R10: the active top is never zero
  p_top_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    top_q != '0)
    else $error("zero top");
endmodule

// File: tb/pwm_pulse_gen_test.sv
module pwm_pulse_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, mode_i = 0, ld_valid_i = 0;
  logic [2:0] prescale_i = 0;
  logic [3:0] ch_en_i = 4'hF;
  logic [63:0] ld_duty_i = '0;
  logic [14:0] ld_top_i = '0;
  logic ld_ready_o, period_end_o;
  logic [3:0] pwm_o;

  int tests = 0, fails = 0;
  string tag = "R1";

  // behavioural reference state
  int m_run = 0, m_cnt = 0, m_up = 1, m_pc = 0, m_ps = 0, m_mode = 0;
  int m_top = 1, m_stopp = 0, m_pend = 0, m_taken = 0;
  int m_cmp[NCH];
  int m_inv[NCH];

  pwm_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .mode_i(mode_i), .prescale_i(prescale_i), .ch_en_i(ch_en_i),
    .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o), .ld_duty_i(ld_duty_i),
    .ld_top_i(ld_top_i), .pwm_o(pwm_o), .period_end_o(period_end_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit m_tick();
    return m_run != 0 && ((m_pc % (1 << m_ps)) == (1 << m_ps) - 1);
  endfunction
  function automatic bit m_last();
    if (m_mode != 0) return (m_up == 0 && m_cnt == 0);
    return m_cnt == m_top - 1;
  endfunction
  function automatic bit m_ready();
    return m_run == 0 || (m_tick() && m_last());
  endfunction
  function automatic logic [3:0] m_out();
    logic [3:0] v;
    for (int i = 0; i < NCH; i++)
      v[i] = (m_run != 0) && ch_en_i[i] && ((m_cnt < m_cmp[i]) != (m_inv[i] != 0));
    return v;
  endfunction

  task automatic model_update();
    bit t, w, r;
    t = m_tick(); w = t && m_last(); r = m_ready();
    m_taken = 0;
    if (ld_valid_i && r) begin
      m_taken = 1;
      m_top = (ld_top_i == 0) ? 1 : int'(ld_top_i);
      for (int i = 0; i < NCH; i++) begin
        m_cmp[i] = int'(ld_duty_i[i*16 +: 15]);
        m_inv[i] = int'(ld_duty_i[i*16 + 15]);
      end
    end
    m_pend = w;
    if (m_run == 0) begin
      if (start_i) begin
        m_run = 1; m_cnt = 0; m_up = 1; m_pc = 0; m_stopp = 0;
        m_mode = int'(mode_i); m_ps = int'(prescale_i);
      end
    end else begin
      m_pc = (m_pc + 1) % 128;
      if (w) begin
        m_cnt = 0; m_up = 1;
        if (m_stopp != 0 || stop_i) m_run = 0;
        m_stopp = 0;
      end else begin
        if (t) begin
          if (m_mode == 0) m_cnt++;
          else if (m_up != 0) begin
            if (m_cnt == m_top - 1) m_up = 0; else m_cnt++;
          end else m_cnt--;
        end
        if (stop_i) m_stopp = 1;
      end
    end
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(tag, "pwm_o", 32'(pwm_o), 32'(m_out()));
    check("R6", "period_end_o", 32'(period_end_o), 32'(m_pend));
    check("R7", "ld_ready_o", 32'(ld_ready_o), 32'(m_ready()));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    if (m_taken != 0) ld_valid_i = 0;
    start_i = 0;
    stop_i = 0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic set_duty(int ch, int inv, int cmp);
    ld_duty_i[ch*16 +: 16] = {inv[0], cmp[14:0]};
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin m_cmp[i] = 0; m_inv[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pwm_o", 32'(pwm_o), 0);
    check("R1", "period_end_o", 32'(period_end_o), 0);
    check("R1", "ld_ready_o", 32'(ld_ready_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R3/R5: edge-aligned, full-duty, zero-duty and inverted channels
    tag = "R3";
    set_duty(0, 0, 3); set_duty(1, 1, 5); set_duty(2, 0, 8); set_duty(3, 0, 0);
    ld_top_i = 8; ld_valid_i = 1; start_i = 1;
    run(40);

    // R7/R5: new values held on the port until the period boundary
    tag = "R7";
    set_duty(0, 1, 2); set_duty(1, 0, 4); set_duty(2, 1, 0); set_duty(3, 0, 9);
    ld_top_i = 6; ld_valid_i = 1;
    run(30);
    tag = "R5";
    run(12);

    // R8: stop mid-period, then idle
    tag = "R8";
    run(3); stop_i = 1;
    run(20);
    stop_i = 1; run(3);

    // R2: restart with divide-by-4
    tag = "R2";
    prescale_i = 2; start_i = 1;
    run(60);
    // R8: start while running is ignored
    tag = "R8";
    start_i = 1; run(10);

    // R11: mode and prescale changes while running have no effect
    tag = "R11";
    mode_i = 1; prescale_i = 0;
    run(40);

    // R4: center-aligned with divide-by-2
    tag = "R4";
    stop_i = 1; run(40);
    mode_i = 1; prescale_i = 1;
    set_duty(0, 0, 2); set_duty(1, 1, 3); set_duty(2, 0, 5); set_duty(3, 0, 1);
    ld_top_i = 5; ld_valid_i = 1; start_i = 1;
    run(60);

    // R9: unconnected channels stay low
    tag = "R9";
    ch_en_i = 4'b0101;
    run(30);
    ch_en_i = 4'hF;

    // R10: top of zero behaves as one
    tag = "R10";
    set_duty(0, 0, 1); set_duty(1, 1, 1); set_duty(2, 0, 0); set_duty(3, 1, 0);
    ld_top_i = 0; ld_valid_i = 1;
    run(30);

    // R2: slowest prescale in edge mode
    tag = "R2";
    stop_i = 1; run(20);
    mode_i = 0; prescale_i = 7;
    set_duty(0, 0, 1); set_duty(1, 0, 2); set_duty(2, 1, 1); set_duty(3, 0, 3);
    ld_top_i = 3; ld_valid_i = 1; start_i = 1;
    run(900);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule